// File: doc/BRIEF.md
# Eight-Function Nibble Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for two unsigned 4-bit operands. A 3-bit operation code picks one of eight functions: sum, difference, a one-place left shift of the second operand, negation of either operand, unsigned absolute difference, the full product and the unsigned minimum. The answer appears on an 8-bit result bus. Only the product uses the upper four bits; every other function leaves them at zero.

Two flags come with the result. The carry flag is the raw carry-out of the shared 4-bit adder. The overflow flag reports two's-complement signed overflow of that adder. Both flags are live only for the sum, the difference and the absolute difference. Every other operation code forces them low.

The unit sits directly between operand registers and a result register owned by the surrounding datapath. It holds no state and takes no clock.

Top module: `nibble_alu`

## Requirements
- R1: Code 000 gives (A+B) mod 16 on result[3:0]. carry_out is the bit-4 carry of A+B. ovf_out is 1 when the signed sum of A and B, each read as a signed 4-bit value, falls outside -8..7.
- R2: Code 001 gives (A-B) mod 16, computed as A+~B+1. carry_out is 1 exactly when A>=B unsigned (no borrow). ovf_out is 1 when the signed difference falls outside -8..7.
- R3: Code 010 gives B shifted left one place: result[3:1]=B[2:0], result[0]=0, and B[3] is discarded.
- R4: Code 011 gives the two's-complement negation (0-A) mod 16.
- R5: Code 100 gives the two's-complement negation (0-B) mod 16.
- R6: Code 101 gives |A-B|, with A and B unsigned. carry_out and ovf_out take the values that code 001 gives for the same A and B.
- R7: Code 110 gives the unsigned 8-bit product A*B on result[7:0].
- R8: Code 111 gives the smaller of A and B, compared unsigned.
- R9: For every code other than 110, result[7:4] is 0.
- R10: For codes 010, 011, 100, 110 and 111, carry_out and ovf_out are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | 4 | First operand A |
| opd_b | input | 4 | Second operand B |
| op_sel | input | 3 | Operation code |
| result | output | 8 | Result bus; upper nibble used only by the product |
| carry_out | output | 1 | Adder carry-out for sum, difference and absolute difference |
| ovf_out | output | 1 | Signed overflow for sum, difference and absolute difference |

## Verification
The hardest flag case is the overflow flag under absolute difference. Its value follows the internal signed subtraction, not the non-negative result that appears on the port. It is set only for operand pairs whose signs differ when read as signed values, such as A=0 with B=8, or A=7 with B=15. There the result is a small unsigned magnitude while the flag still reports the hidden overflow. The stimulus sweeps all 256 operand pairs for every operation code, so each of these pairs is reached. A dedicated task also applies the named extreme pairs and checks the flags and the magnitude together.

// File: rtl/nibble_alu_pkg.sv
// Package: shared operation encoding for the nibble ALU.
// Assumes the operation code is exactly three bits wide.
package nibble_alu_pkg;
    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_SHL  = 3'b010,
        OP_NEGA = 3'b011,
        OP_NEGB = 3'b100,
        OP_ABSD = 3'b101,
        OP_MUL  = 3'b110,
        OP_MIN  = 3'b111
    } alu_op_e;
endpackage

// File: rtl/rc_adder.sv
// Ripple-carry adder of W bits with carry-in.
// Gives the sum, the carry-out and the two's-complement overflow,
// taken as the XOR of the carries into and out of the top bit.
// Assumes W >= 2.
module rc_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0] carry;

    assign carry[0] = cin;

    // One full adder per bit position, chained through carry.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = x[i] ^ y[i] ^ carry[i];
        assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
    end

    assign cout = carry[W];
    assign ovf  = carry[W] ^ carry[W-1];
endmodule

// File: rtl/twos_negate.sv
// Two's-complement negation of a W-bit value (~v + 1).
// Uses a ripple incrementer with no flags. Assumes W >= 1.
module twos_negate #(
    parameter int W = 4
) (
    input  logic [W-1:0] v,
    output logic [W-1:0] neg
);
    logic [W:0]   inc_c;
    logic [W-1:0] inv;

    assign inv      = ~v;
    assign inc_c[0] = 1'b1;

    // Half-adder chain adds the constant one to the inverted value.
    for (genvar i = 0; i < W; i++) begin : g_inc
        assign neg[i]     = inv[i] ^ inc_c[i];
        assign inc_c[i+1] = inv[i] & inc_c[i];
    end
endmodule

// File: rtl/array_mult.sv
// Unsigned W x W multiplier with a 2W-bit product.
// Forms one shifted partial product per bit of b and sums them
// through an accumulate chain. Assumes unsigned operands.
module array_mult #(
    parameter int W = 4
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [PW-1:0] acc [0:W];

    assign acc[0] = '0;

    // Each row adds a shifted copy of a, gated by one bit of b.
    for (genvar i = 0; i < W; i++) begin : g_row
        logic [PW-1:0] row;
        assign row      = b[i] ? (PW'(a) << i) : '0;
        assign acc[i+1] = acc[i] + row;
    end

    assign prod = acc[W];
endmodule

// File: rtl/nibble_alu.sv
// Eight-function combinational ALU (top).
// One shared adder serves sum, difference, both negations, the sign
// test for absolute difference and the comparison for minimum.
// The product has its own array. Flags are enabled only for sum,
// difference and absolute difference. Holds no state.
module nibble_alu
    import nibble_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0]   opd_a,
    input  logic [W-1:0]   opd_b,
    input  logic [2:0]     op_sel,
    output logic [2*W-1:0] result,
    output logic           carry_out,
    output logic           ovf_out
);
    localparam int RW = 2 * W;

    alu_op_e      op;
    logic         neg_a, neg_b, invert;
    logic [W-1:0] x_op, y_raw, y_op;
    logic [W-1:0] main_sum;
    logic         main_c, main_v;
    logic [W-1:0] neg_diff, abs_val, min_val, shl_val;
    logic [RW-1:0] prod;
    logic         flag_en;

    assign op = alu_op_e'(op_sel);

    // Operand steering for the shared adder.
    always_comb begin
        neg_a  = (op == OP_NEGA);
        neg_b  = (op == OP_NEGB);
        invert = (op != OP_ADD);
        x_op   = (neg_a | neg_b) ? '0 : opd_a;
        y_raw  = neg_a ? opd_a : opd_b;
        y_op   = invert ? ~y_raw : y_raw;
    end

    rc_adder #(.W(W)) u_main_add (
        .x    (x_op),
        .y    (y_op),
        .cin  (invert),
        .sum  (main_sum),
        .cout (main_c),
        .ovf  (main_v)
    );

    // Negated difference, used when A < B under absolute difference.
    twos_negate #(.W(W)) u_diff_neg (
        .v   (main_sum),
        .neg (neg_diff)
    );

    array_mult #(.W(W)) u_mult (
        .a    (opd_a),
        .b    (opd_b),
        .prod (prod)
    );

    // Magnitude, minimum and shift derive from the adder's borrow.
    always_comb begin
        abs_val = main_c ? main_sum : neg_diff;
        min_val = main_c ? opd_b : opd_a;
        shl_val = {opd_b[W-2:0], 1'b0};
    end

    // Result selection by operation code.
    always_comb begin
        result = '0;
        unique case (op)
            OP_ADD, OP_SUB, OP_NEGA, OP_NEGB: result[W-1:0] = main_sum;
            OP_SHL:  result[W-1:0] = shl_val;
            OP_ABSD: result[W-1:0] = abs_val;
            OP_MUL:  result        = prod;
            OP_MIN:  result[W-1:0] = min_val;
            default: result        = '0;
        endcase
    end

    // Flags are masked outside the three arithmetic codes.
    always_comb begin
        flag_en   = (op == OP_ADD) || (op == OP_SUB) || (op == OP_ABSD);
        carry_out = flag_en & main_c;
        ovf_out   = flag_en & main_v;
    end
endmodule

// File: rtl/nibble_alu_chk.sv
// Checker for nibble_alu, bound to every instance.
// The unit is combinational, so the checks are immediate assertions
// evaluated on settled port values.
module nibble_alu_chk #(
    parameter int W = 4
) (
    input logic [W-1:0]   opd_a,
    input logic [W-1:0]   opd_b,
    input logic [2:0]     op_sel,
    input logic [2*W-1:0] result,
    input logic           carry_out,
    input logic           ovf_out
);
    // Port relations per operation code.
    always_comb begin
        if (op_sel != 3'b110) begin
            p_upper_zero_r9: assert (result[2*W-1:W] == '0)
                else $error("upper result bits set outside product");
        end
        if (op_sel == 3'b010 || op_sel == 3'b011 || op_sel == 3'b100 ||
            op_sel == 3'b110 || op_sel == 3'b111) begin
            p_flags_low_r10: assert (!carry_out && !ovf_out)
                else $error("flag raised on flagless operation");
        end
        if (op_sel == 3'b010) begin
            p_shift_fill_r3: assert (result[0] == 1'b0)
                else $error("shift did not fill bit 0 with zero");
        end
        if (op_sel == 3'b111) begin
            p_min_bound_r8: assert (result[W-1:0] <= opd_a && result[W-1:0] <= opd_b)
                else $error("minimum exceeds an operand");
        end
        if (op_sel == 3'b110) begin
            p_product_r7: assert (result == (2*W)'(opd_a) * (2*W)'(opd_b))
                else $error("product mismatch");
        end
        if (op_sel == 3'b001) begin
            p_borrow_carry_r2: assert (carry_out == (opd_a >= opd_b))
                else $error("difference carry does not match borrow");
        end
    end
endmodule

bind nibble_alu nibble_alu_chk #(.W(W)) u_chk (
    .opd_a     (opd_a),
    .opd_b     (opd_b),
    .op_sel    (op_sel),
    .result    (result),
    .carry_out (carry_out),
    .ovf_out   (ovf_out)
);

// File: tb/nibble_alu_test.sv
// Directed bench for nibble_alu: one task per scenario, exhaustive
// operand sweeps against an integer reference model.
module nibble_alu_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] a, b;
    logic [2:0] sel;
    logic [7:0] res;
    logic       cf, vf;
    int         n_chk = 0;
    int         n_bad = 0;
    int         cycles = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    nibble_alu uut (
        .opd_a     (a),
        .opd_b     (b),
        .op_sel    (sel),
        .result    (res),
        .carry_out (cf),
        .ovf_out   (vf)
    );

    // Watchdog: a hung run counts as a failure and still summarises.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input int got, input int exp, input string what);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: a=%0d b=%0d sel=%0d got %0d expected %0d",
                     req, what, a, b, sel, got, exp);
        end
    endtask

    function automatic int sx(input int v);
        return (v > 7) ? v - 16 : v;
    endfunction

    function automatic int ovf4(input int s);
        return (s > 7 || s < -8) ? 1 : 0;
    endfunction

    // Reference model computed from the requirements.
    task automatic model(input int op, input int x, input int y,
                         output int r, output int c, output int v);
        r = 0; c = 0; v = 0;
        case (op)
            0: begin r = (x + y) & 15; c = (x + y) >> 4; v = ovf4(sx(x) + sx(y)); end
            1: begin r = (x - y) & 15; c = (x >= y); v = ovf4(sx(x) - sx(y)); end
            2: r = (y << 1) & 15;
            3: r = (16 - x) & 15;
            4: r = (16 - y) & 15;
            5: begin r = (x >= y) ? x - y : y - x; c = (x >= y); v = ovf4(sx(x) - sx(y)); end
            6: r = x * y;
            default: r = (x < y) ? x : y;
        endcase
    endtask

    task automatic apply(input int op, input int x, input int y, input string req);
        int er, ec, ev;
        @(posedge clk);
        sel = 3'(op); a = 4'(x); b = 4'(y);
        @(negedge clk);
        model(op, x, y, er, ec, ev);
        if (op == 6) begin
            check(req, int'(res), er, "product");
        end else begin
            check(req, int'(res[3:0]), er, "low nibble");
            check("R9", int'(res[7:4]), 0, "upper nibble");
        end
        if (op == 0 || op == 1 || op == 5) begin
            check(req, int'(cf), ec, "carry");
            check(req, int'(vf), ev, "overflow");
        end else begin
            check("R10", int'(cf), 0, "carry");
            check("R10", int'(vf), 0, "overflow");
        end
    endtask

    task automatic sweep(input int op, input string req);
        for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
                apply(op, x, y, req);
    endtask

    task automatic test_reset_state();
        @(negedge clk);
        check("R1", int'(res), 0, "idle result");
        check("R1", int'(cf), 0, "idle carry");
        check("R1", int'(vf), 0, "idle overflow");
    endtask

    task automatic test_add();   sweep(0, "R1"); endtask
    task automatic test_sub();   sweep(1, "R2"); endtask
    task automatic test_shift(); sweep(2, "R3"); endtask
    task automatic test_nega();  sweep(3, "R4"); endtask
    task automatic test_negb();  sweep(4, "R5"); endtask
    task automatic test_absd();  sweep(5, "R6"); endtask
    task automatic test_mul();   sweep(6, "R7"); endtask
    task automatic test_min();   sweep(7, "R8"); endtask

    // Named extremes: signed overflow hidden behind an unsigned magnitude.
    task automatic test_corners();
        apply(5, 0, 8, "R6");
        check("R6", int'(vf), 1, "abs overflow 0 vs 8");
        check("R6", int'(res), 8, "abs value 0 vs 8");
        apply(5, 7, 15, "R6");
        check("R6", int'(vf), 1, "abs overflow 7 vs 15");
        apply(0, 7, 1, "R1");
        check("R1", int'(vf), 1, "add overflow 7+1");
        apply(1, 8, 1, "R2");
        check("R2", int'(vf), 1, "sub overflow -8-1");
        apply(6, 15, 15, "R7");
        check("R7", int'(res), 225, "max product");
        apply(2, 15, 8, "R3");
        check("R3", int'(res), 0, "shift drops top bit");
    endtask

    initial begin
        a = '0; b = '0; sel = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        test_reset_state();
        test_add();
        test_sub();
        test_shift();
        test_nega();
        test_negb();
        test_absd();
        test_mul();
        test_min();
        test_corners();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule